// File: doc/BRIEF.md
# Pin-Qualified Receive Gain Loader

This block lets an external controller set a 5-bit receive gain over the 6-bit transmit data bus, so no serial access is needed. On every rising edge of the sampling clock it looks at a gain qualifier pin, the word-sync line and the upper five bus bits. A gain write is accepted only after the qualifier has been high, sync has been low and the upper five bits have not changed for three edges in a row. The write then loads the gain register and pulses an update strobe. While the qualifier is low, the bus carries ordinary transmit samples, and the block forwards them to the data path.

A register-side parallel load path can also write the gain. It wins over a pin write that lands on the same edge. Every gain update, from either path, is followed by a one-cycle gain-applied pulse a fixed number of sampling cycles later. This pulse marks the point at which the new gain shows up in converted samples.

Top module: `gain_pin_loader`

## Requirements
- R1: While rst_n is low and on the first edge after it, gainVal is 0, gainUpd and gainApplied are 0, txDataValid is 0 and txData is 0.
- R2: An edge is qualifying when gainQual=1 and syncLvl=0. On the third consecutive qualifying edge at which txBus[5:1] has stayed the same, gainVal takes txBus[5:1] and gainUpd is 1 for exactly that one cycle. txBus[0] plays no part in the value or in the comparison.
- R3: A run of fewer than three consecutive qualifying edges with the same data writes nothing.
- R4: An edge with gainQual=1 and syncLvl=1 writes nothing, and it ends any run in progress.
- R5: A change of txBus[5:1] during a qualifying run starts the count again at one, so three more stable edges are needed.
- R6: While the qualifier stays asserted with unchanged data after a pin write, no further pin write occurs until the run is broken.
- R7: regWrEn=1 at an edge loads regWrData into gainVal at that edge and sets gainUpd=1 for one cycle.
- R8: When regWrEn and a completing pin write fall on the same edge, regWrData is stored and only one gainUpd pulse is produced.
- R9: gainApplied is 1 exactly seven cycles after each cycle in which gainUpd is 1, and is 0 at all other times.
- R10: After an edge with gainQual=0, txData equals the txBus sampled at that edge and txDataValid=1. After an edge with gainQual=1, txDataValid=0 and txData keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| gainQual | input | 1 | Gain qualifier pin; high selects gain programming |
| syncLvl | input | 1 | Word-sync line; must be low for a gain write |
| txBus | input | 6 | Shared transmit data / gain bus |
| regWrEn | input | 1 | Register-side gain load enable |
| regWrData | input | 5 | Register-side gain value |
| gainVal | output | 5 | Current receive gain |
| gainUpd | output | 1 | One-cycle pulse when gainVal is written |
| gainApplied | output | 1 | One-cycle pulse seven cycles after each update |
| txData | output | 6 | Transmit sample forwarded to the data path |
| txDataValid | output | 1 | txData holds a sample taken at the last edge |

## Verification
The properties assume that the inputs are driven synchronously and are settled at each rising edge. They also assume that regWrEn is low during reset, because several checks refer to the previous cycle's load enable. The stimulus changes inputs only on falling edges and keeps every control low while reset is held. It exercises runs of two, three and more qualifying edges, data changes in the middle of a run, toggling of the ignored bit zero, and a register load that coincides with a completing pin run.

// File: rtl/gain_pin_pkg.sv
package gain_pin_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic pinLoad;  // load gain from the bus
    logic regLoad;  // load gain from the register port
  } gainStrobes_t;
endpackage

// File: rtl/gain_pin_ctrl.sv
module gain_pin_ctrl
  import gain_pin_pkg::*;
#(
  parameter int GAIN_W      = 5,
  parameter int BUS_W       = 6,
  parameter int HOLD_CYCLES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gainQual,
  input  logic             syncLvl,
  input  logic [BUS_W-1:0] txBus,
  input  logic             regWrEn,
  output gainStrobes_t     strobes
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] HOLD_C  = CW'(HOLD_CYCLES);
  localparam logic [CW-1:0] HOLD_M1 = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0]     runLen, runNext;
  logic [GAIN_W-1:0] lastData, busGain;
  logic              qualNow, sameData;

  assign busGain  = txBus[BUS_W-1 -: GAIN_W];
  assign qualNow  = gainQual && !syncLvl;
  assign sameData = (runLen != '0) && (busGain == lastData);

  always_comb begin
    if (!qualNow)          runNext = '0;
    else if (!sameData)    runNext = CW'(1);
    else if (runLen == HOLD_C) runNext = HOLD_C;
    else                   runNext = runLen + CW'(1);
  end

  // one pin write per window: only on the transition into the full count
  always_comb begin
    strobes.regLoad = regWrEn;
    strobes.pinLoad = qualNow && (runNext == HOLD_C) && (runLen == HOLD_M1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      runLen   <= '0;
      lastData <= '0;
    end else begin
      runLen   <= runNext;
      lastData <= busGain;
    end
  end
endmodule

// File: rtl/gain_pin_dpath.sv
module gain_pin_dpath
  import gain_pin_pkg::*;
#(
  parameter int GAIN_W      = 5,
  parameter int BUS_W       = 6,
  parameter int APPLY_DELAY = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  gainStrobes_t      strobes,
  input  logic              gainQual,
  input  logic [BUS_W-1:0]  txBus,
  input  logic [GAIN_W-1:0] regWrData,
  output logic [GAIN_W-1:0] gainVal,
  output logic              gainUpd,
  output logic              gainApplied,
  output logic [BUS_W-1:0]  txData,
  output logic              txDataValid
);
  logic [APPLY_DELAY-1:0] applyPipe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gainVal <= '0;
      gainUpd <= 1'b0;
    end else begin
      gainUpd <= strobes.regLoad || strobes.pinLoad;
      if (strobes.regLoad)      gainVal <= regWrData;
      else if (strobes.pinLoad) gainVal <= txBus[BUS_W-1 -: GAIN_W];
    end
  end

  generate
    if (APPLY_DELAY == 1) begin : g_short
      always_ff @(posedge clk) begin
        if (!rst_n) applyPipe <= '0;
        else        applyPipe <= gainUpd;
      end
    end else begin : g_long
      always_ff @(posedge clk) begin
        if (!rst_n) applyPipe <= '0;
        else        applyPipe <= {applyPipe[APPLY_DELAY-2:0], gainUpd};
      end
    end
  endgenerate
  assign gainApplied = applyPipe[APPLY_DELAY-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txData      <= '0;
      txDataValid <= 1'b0;
    end else begin
      txDataValid <= !gainQual;
      if (!gainQual) txData <= txBus;
    end
  end
endmodule

// File: rtl/gain_pin_loader.sv
module gain_pin_loader
  import gain_pin_pkg::*;
#(
  parameter int GAIN_W      = 5,
  parameter int BUS_W       = 6,
  parameter int HOLD_CYCLES = 3,
  parameter int APPLY_DELAY = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gainQual,
  input  logic              syncLvl,
  input  logic [BUS_W-1:0]  txBus,
  input  logic              regWrEn,
  input  logic [GAIN_W-1:0] regWrData,
  output logic [GAIN_W-1:0] gainVal,
  output logic              gainUpd,
  output logic              gainApplied,
  output logic [BUS_W-1:0]  txData,
  output logic              txDataValid
);
  gainStrobes_t strobes;

  gain_pin_ctrl #(.GAIN_W(GAIN_W), .BUS_W(BUS_W), .HOLD_CYCLES(HOLD_CYCLES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .gainQual(gainQual), .syncLvl(syncLvl),
    .txBus(txBus), .regWrEn(regWrEn), .strobes(strobes)
  );

  gain_pin_dpath #(.GAIN_W(GAIN_W), .BUS_W(BUS_W), .APPLY_DELAY(APPLY_DELAY)) dpath_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .gainQual(gainQual),
    .txBus(txBus), .regWrData(regWrData), .gainVal(gainVal), .gainUpd(gainUpd),
    .gainApplied(gainApplied), .txData(txData), .txDataValid(txDataValid)
  );
endmodule

// File: rtl/gain_pin_loader_chk.sv
module gain_pin_loader_chk #(
  parameter int GAIN_W      = 5,
  parameter int BUS_W       = 6,
  parameter int HOLD_CYCLES = 3,
  parameter int APPLY_DELAY = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gainQual,
  input logic              syncLvl,
  input logic [BUS_W-1:0]  txBus,
  input logic              regWrEn,
  input logic [GAIN_W-1:0] regWrData,
  input logic [GAIN_W-1:0] gainVal,
  input logic              gainUpd,
  input logic              gainApplied,
  input logic [BUS_W-1:0]  txData,
  input logic              txDataValid
);
  // checker-side history of update pulses, sized by the delay parameter
  logic [APPLY_DELAY-1:0] updHist;
  always_ff @(posedge clk) begin
    if (!rst_n) updHist <= '0;
    else        updHist <= {updHist, gainUpd} >> 0;
  end
  logic histTap;
  assign histTap = (APPLY_DELAY == 1) ? gainUpd : updHist[APPLY_DELAY-1];

  AST_REG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    regWrEn |=> gainUpd && gainVal == $past(regWrData)); // R7
  AST_SYNC_HIGH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (gainQual && syncLvl && !regWrEn) |=> !gainUpd); // R4
  AST_PIN_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (gainUpd && !$past(regWrEn)) |-> ($past(gainQual && !syncLvl) && gainVal == $past(txBus[BUS_W-1 -: GAIN_W]))); // R2
  AST_SINGLE_PIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (gainUpd && !$past(regWrEn)) |=> (!gainUpd || $past(regWrEn))); // R6
  AST_GAIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !gainUpd |-> $stable(gainVal)); // R2
  AST_APPLY_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    gainApplied == histTap); // R9
  AST_TX_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    !gainQual |=> txDataValid && txData == $past(txBus)); // R10
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    gainQual |=> !txDataValid && $stable(txData)); // R10
endmodule

bind gain_pin_loader gain_pin_loader_chk #(
  .GAIN_W(GAIN_W), .BUS_W(BUS_W), .HOLD_CYCLES(HOLD_CYCLES), .APPLY_DELAY(APPLY_DELAY)
) chk_i (.*);

// File: tb/gain_pin_loader_tb_top.sv
module gain_pin_loader_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gainQual = 1'b0, syncLvl = 1'b0, regWrEn = 1'b0;
  logic [5:0] txBus = '0;
  logic [4:0] regWrData = '0;
  logic [4:0] gainVal;
  logic       gainUpd, gainApplied, txDataValid;
  logic [5:0] txData;

  always #4 clk = ~clk; // 125 MHz

  gain_pin_loader dut_i (
    .clk(clk), .rst_n(rst_n), .gainQual(gainQual), .syncLvl(syncLvl), .txBus(txBus),
    .regWrEn(regWrEn), .regWrData(regWrData), .gainVal(gainVal), .gainUpd(gainUpd),
    .gainApplied(gainApplied), .txData(txData), .txDataValid(txDataValid)
  );

  int testsRun = 0, testsFailed = 0;
  string curReq = "R1";

  // behavioural reference model
  int   runLen = 0, lastD = 0, expGain = 0, expTx = 0;
  bit   expUpd = 0, expApplied = 0, expValid = 0;
  bit   updHist[$];
  int   updCount = 0, appliedCount = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      runLen = 0; lastD = 0; expGain = 0; expUpd = 0; expApplied = 0;
      expTx = 0; expValid = 0; updHist.delete();
    end else begin
      int  d, nrun;
      bit  q, same, fire;
      q    = gainQual && !syncLvl;
      d    = int'(txBus[5:1]);
      same = (runLen > 0) && (d == lastD);
      nrun = !q ? 0 : (same ? ((runLen + 1 > 3) ? 3 : runLen + 1) : 1);
      fire = q && nrun == 3 && runLen == 2;
      expUpd = regWrEn || fire;
      if (regWrEn)   expGain = int'(regWrData);
      else if (fire) expGain = d;
      runLen = nrun; lastD = d;
      updHist.push_front(expUpd);
      if (updHist.size() > 8) void'(updHist.pop_back());
      expApplied = (updHist.size() > 7) ? updHist[7] : 1'b0;
      expValid = !gainQual;
      if (!gainQual) expTx = int'(txBus);
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    check(int'(gainVal) == expGain, curReq, "gainVal", int'(gainVal), expGain);
    check(gainUpd == expUpd, curReq, "gainUpd", gainUpd, expUpd);
    check(gainApplied == expApplied, "R9", "gainApplied", gainApplied, expApplied);
    check(txDataValid == expValid, "R10", "txDataValid", txDataValid, expValid);
    check(int'(txData) == expTx, "R10", "txData", int'(txData), expTx);
    if (gainUpd) updCount++;
    if (gainApplied) appliedCount++;
  endtask

  task automatic step(input bit q, input bit s, input logic [5:0] b, input bit we, input logic [4:0] wd);
    gainQual = q; syncLvl = s; txBus = b; regWrEn = we; regWrData = wd;
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compareAll();                        // R1 during reset
    rst_n = 1'b1;
    step(0, 0, 6'h00, 0, 5'h00);
    check(gainVal == 0 && !gainUpd && !gainApplied, "R1", "post-reset", int'(gainVal), 0);

    curReq = "R10";
    for (int i = 0; i < 5; i++) step(0, i[0], 6'(7 * i + 3), 0, 5'h00);
    check(txDataValid && txData == 6'(7 * 4 + 3), "R10", "forward", int'(txData), 31);

    curReq = "R2";
    step(1, 0, 6'b101011, 0, 0);
    step(1, 0, 6'b101010, 0, 0);        // bit 0 differs only
    check(!gainUpd && gainVal == 0, "R3", "two edges", int'(gainVal), 0);
    step(1, 0, 6'b101011, 0, 0);
    check(gainUpd && gainVal == 5'h15, "R2", "third edge", int'(gainVal), 21);
    check(!txDataValid && txData == 6'(31), "R10", "hold", int'(txData), 31);

    curReq = "R6";
    for (int i = 0; i < 4; i++) step(1, 0, 6'b101011, 0, 0);
    check(!gainUpd, "R6", "no repeat", gainUpd, 0);

    curReq = "R3";
    step(0, 0, 6'h3e, 0, 0);
    step(1, 0, 6'h3e, 0, 0);
    step(1, 0, 6'h3e, 0, 0);
    step(0, 0, 6'h3e, 0, 0);
    check(gainVal == 5'h15, "R3", "short run", int'(gainVal), 21);

    curReq = "R5";
    step(1, 0, 6'h08, 0, 0);
    step(1, 0, 6'h08, 0, 0);
    step(1, 0, 6'h10, 0, 0);
    step(1, 0, 6'h10, 0, 0);
    check(gainVal == 5'h15, "R5", "restart", int'(gainVal), 21);
    step(1, 0, 6'h10, 0, 0);
    check(gainUpd && gainVal == 5'h08, "R5", "new value", int'(gainVal), 8);

    curReq = "R4";
    step(0, 0, 6'h00, 0, 0);
    for (int i = 0; i < 5; i++) step(1, 1, 6'h22, 0, 0);
    check(gainVal == 5'h08 && !gainUpd, "R4", "sync high", int'(gainVal), 8);
    step(1, 0, 6'h22, 0, 0);
    step(1, 1, 6'h22, 0, 0);
    step(1, 0, 6'h22, 0, 0);
    step(1, 0, 6'h22, 0, 0);
    check(gainVal == 5'h08, "R4", "run broken", int'(gainVal), 8);

    curReq = "R7";
    step(0, 0, 6'h00, 1, 5'h0a);
    check(gainUpd && gainVal == 5'h0a, "R7", "reg load", int'(gainVal), 10);
    step(0, 0, 6'h00, 0, 5'h1f);

    curReq = "R8";
    step(1, 0, 6'h3c, 0, 0);
    step(1, 0, 6'h3c, 0, 0);
    step(1, 0, 6'h3c, 1, 5'h03);
    check(gainUpd && gainVal == 5'h03, "R8", "reg wins", int'(gainVal), 3);
    step(1, 0, 6'h3c, 0, 0);
    check(!gainUpd && gainVal == 5'h03, "R8", "single pulse", gainUpd, 0);

    curReq = "R9";
    step(0, 0, 6'h00, 0, 0);
    for (int i = 0; i < 10; i++) step(0, 0, 6'(i), 0, 0);
    check(appliedCount == updCount, "R9", "pulse count", appliedCount, updCount);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule